// File: doc/BRIEF.md
# Card Host Transmit FIFO Start Control

This block is the outgoing data buffer of a memory-card host controller. Software pushes data words in through a valid/ready port. A serializer on the card side pulls those words out one at a time. Between the two, the block decides when an outgoing data block may begin on the card bus.

The decision is made in one of two ways. In immediate mode, the block starts as soon as a single word is buffered. In threshold mode, the block waits for a fill level that depends on the block length: the larger the block, the more data is collected before the start.

The block also watches the flow of data. A push into a full buffer raises a sticky overflow flag. A request from the serializer while a started transfer has nothing buffered raises a sticky underflow flag. Software chooses which event clears these flags: a new command, or a read of the status. A small configuration register holds the mode bits, and a write-protect input freezes it.

Top module: `card_tx_fifo_start`

## Requirements
- R1: After a synchronous active-low reset, `fill_level` is 0, `push_ready` is 1, and `ovf_flag`, `udf_flag`, `start_stb`, `xfer_active` and `cfg_rdata` are all 0.
- R2: A `cfg_wr` with `wp_en` low updates the configuration from the next cycle. The kept bits are: bit 0 (immediate start), bit 4 (clear flags on status read), bit 8 (high-speed output timing, on `hs_mode`) and bit 12 (last-block command sync, on `last_sync`). Every other bit of `cfg_rdata` reads 0.
- R3: A `cfg_wr` while `wp_en` is high leaves the configuration unchanged.
- R4: Words leave in push order. `pop_valid` is high exactly when a transfer is active and the FIFO is not empty. `fill_level` counts the buffered words.
- R5: With bit 0 set, a start occurs once at least one word is buffered.
- R6: With bit 0 clear and a block of at least 3/4 DEPTH words (24 by default), a start occurs once DEPTH/2 words (16) are buffered.
- R7: With bit 0 clear and a block of at least DEPTH/2 words but fewer than 3/4 DEPTH (16 to 23), a start occurs once DEPTH/4 words (8) are buffered.
- R8: With bit 0 clear and a block of fewer than DEPTH/2 words, a start occurs only once the whole block is buffered.
- R9: The block length is taken in bytes and rounded up to whole 4-byte words. A length of 0 counts as one word.
- R10: `start_stb` is a one-cycle pulse. It is issued in the cycle after the start condition holds while idle, and it rises together with `xfer_active`. There is one pulse per block.
- R11: `xfer_active` falls in the cycle after the last word of the block is popped. The start decision then re-arms for the next block.
- R12: A push while the FIFO is full is dropped. It sets `ovf_flag` from the next cycle, and `push_ready` is low while the FIFO is full.
- R13: A `pop_req` while a transfer is active and the FIFO is empty sets `udf_flag` from the next cycle.
- R14: The flags are cleared as follows. With bit 4 clear, `cmd_new` clears them and `stat_rd` does not. With bit 4 set, `stat_rd` clears them and `cmd_new` does not. A new error event in the same cycle as a clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| wp_en | input | 1 | Write-protect enable for the configuration |
| cfg_rdata | output | 32 | Configuration readback |
| hs_mode | output | 1 | High-speed output timing select |
| last_sync | output | 1 | Last-block command synchronisation select |
| blk_bytes | input | BLEN_W | Block length in bytes |
| cmd_new | input | 1 | New read/write command pulse |
| stat_rd | input | 1 | Status read pulse |
| push_valid | input | 1 | Software word valid |
| push_data | input | DATA_W | Software word |
| push_ready | output | 1 | FIFO can accept a word |
| pop_req | input | 1 | Serializer requests a word |
| pop_valid | output | 1 | A word is offered to the serializer |
| pop_data | output | DATA_W | Word offered to the serializer |
| start_stb | output | 1 | One-cycle start-transfer pulse |
| xfer_active | output | 1 | Block transfer in progress |
| fill_level | output | $clog2(DEPTH+1) | Number of buffered words |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with its defaults: 32-bit words, 32 entries and 16-bit lengths. With these values the three threshold bands sit at 24 and 16 words, so lengths between 0 and a few hundred bytes reach every band. Those lengths also reach each band edge (23/24 and 15/16 words) and the byte rounding at odd lengths. Because the FIFO has only 32 entries, overflow is reached after a short burst of pushes. Random push, pop, clear and configuration traffic runs against a cycle model. Directed runs check the exact fill level at which each start pulse appears.

// File: rtl/ctf_pkg.sv
package ctf_pkg;

   localparam int unsigned CTF_REG_W      = 32;
   localparam int unsigned CFG_IMM_BIT    = 0;
   localparam int unsigned CFG_RDCLR_BIT  = 4;
   localparam int unsigned CFG_HS_BIT     = 8;
   localparam int unsigned CFG_LSYNC_BIT  = 12;

   localparam logic [CTF_REG_W-1:0] CTF_CFG_MASK =
      (CTF_REG_W'(1) << CFG_IMM_BIT)   |
      (CTF_REG_W'(1) << CFG_RDCLR_BIT) |
      (CTF_REG_W'(1) << CFG_HS_BIT)    |
      (CTF_REG_W'(1) << CFG_LSYNC_BIT);

   typedef struct packed {
      logic lsync;
      logic hs;
      logic rdclr;
      logic imm;
   } ctf_cfg_t;

   function automatic logic [CTF_REG_W-1:0] ctf_cfg_pack(input ctf_cfg_t c);
      logic [CTF_REG_W-1:0] r;
      r                = '0;
      r[CFG_IMM_BIT]   = c.imm;
      r[CFG_RDCLR_BIT] = c.rdclr;
      r[CFG_HS_BIT]    = c.hs;
      r[CFG_LSYNC_BIT] = c.lsync;
      return r;
   endfunction

   function automatic ctf_cfg_t ctf_cfg_unpack(input logic [CTF_REG_W-1:0] w);
      ctf_cfg_t c;
      c.imm   = w[CFG_IMM_BIT];
      c.rdclr = w[CFG_RDCLR_BIT];
      c.hs    = w[CFG_HS_BIT];
      c.lsync = w[CFG_LSYNC_BIT];
      return c;
   endfunction

endpackage

// File: rtl/ctf_cfg_reg.sv
module ctf_cfg_reg
   import ctf_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wp_en,
   input  logic [CTF_REG_W-1:0] wdata,
   output ctf_cfg_t             cfg,
   output logic [CTF_REG_W-1:0] rdata
);

   initial begin
      assert (CFG_LSYNC_BIT < CTF_REG_W) else $error("config field beyond register width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en && !wp_en) begin
         cfg <= ctf_cfg_unpack(wdata);
      end
   end

   assign rdata = ctf_cfg_pack(cfg);

   // R2: spare bits never read as one
   p_spare_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~CTF_CFG_MASK) == '0);

   // R2: an unprotected write lands one cycle later
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wp_en |=> rdata == ($past(wdata) & CTF_CFG_MASK));

   // R3: a protected write is ignored
   p_wp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wp_en |=> $stable(rdata));

endmodule

// File: rtl/ctf_fifo_store.sv
module ctf_fifo_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_en,
   input  logic [DATA_W-1:0]          push_data,
   input  logic                       pop_en,
   output logic [DATA_W-1:0]          pop_data,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       full,
   output logic                       empty
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned LVL_W = $clog2(DEPTH + 1);
   localparam bit          POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   initial begin
      assert (DEPTH >= 4) else $error("DEPTH must be at least 4");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [PTR_W-1:0]  wr_nxt, rd_nxt;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_en) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_en) wr_ptr <= wr_nxt;
         if (pop_en)  rd_ptr <= rd_nxt;
         case ({push_en, pop_en})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign pop_data = mem[rd_ptr];
   assign full     = (level == LVL_W'(DEPTH));
   assign empty    = (level == '0);

   // R12: the write side never stores into a full buffer
   p_no_push_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |-> !full);

   // R4: the read side never takes from an empty buffer
   p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> !empty);

   // R4: a lone push raises the level by one
   p_level_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push_en && !pop_en |=> level == LVL_W'($past(level) + 1'b1));

   // R4: level never exceeds capacity
   p_level_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

endmodule

// File: rtl/ctf_start_ctrl.sv
module ctf_start_ctrl #(
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned BLEN_W   = 16,
   parameter int unsigned BPW_LOG  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [BLEN_W-1:0]          blk_bytes,
   input  logic                       imm_mode,
   input  logic [$clog2(DEPTH+1)-1:0] level,
   input  logic                       pop_en,
   output logic                       start_stb,
   output logic                       active
);

   localparam int unsigned LVL_W   = $clog2(DEPTH + 1);
   localparam int unsigned WORDS_W = BLEN_W + 1;
   localparam int unsigned Q3      = (3 * DEPTH) / 4;
   localparam int unsigned HALF    = DEPTH / 2;
   localparam int unsigned QTR     = DEPTH / 4;

   initial begin
      assert (DEPTH % 4 == 0) else $error("DEPTH must be a multiple of 4");
      assert (LVL_W <= WORDS_W) else $error("BLEN_W too narrow for DEPTH");
   end

   logic [WORDS_W-1:0] words;
   logic [WORDS_W-1:0] popped;
   logic [LVL_W-1:0]   thr;
   logic               go;
   logic               last;

   generate
      if (BPW_LOG == 0) begin : g_byte_words
         assign words = (blk_bytes == '0) ? WORDS_W'(1) : {1'b0, blk_bytes};
      end else begin : g_round_words
         logic [WORDS_W-1:0] sum;
         assign sum   = {1'b0, blk_bytes} + WORDS_W'((1 << BPW_LOG) - 1);
         assign words = (blk_bytes == '0) ? WORDS_W'(1) : (sum >> BPW_LOG);
      end
   endgenerate

   always_comb begin
      if (imm_mode)                     thr = LVL_W'(1);
      else if (words >= WORDS_W'(Q3))   thr = LVL_W'(HALF);
      else if (words >= WORDS_W'(HALF)) thr = LVL_W'(QTR);
      else                              thr = words[LVL_W-1:0];
   end

   assign go   = !active && (level >= thr);
   assign last = (popped == words - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_stb <= 1'b0;
         active    <= 1'b0;
         popped    <= '0;
      end else begin
         start_stb <= go;
         if (go) begin
            active <= 1'b1;
            popped <= '0;
         end else if (pop_en) begin
            if (last) begin
               active <= 1'b0;
               popped <= '0;
            end else begin
               popped <= popped + 1'b1;
            end
         end
      end
   end

   // R5: immediate mode starts on the first buffered word
   p_imm_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      imm_mode && !active && level != '0 |=> start_stb);

   // R6: large blocks wait for half the buffer
   p_hold_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !imm_mode && words >= WORDS_W'(Q3) && !active && level < LVL_W'(HALF) |=> !start_stb);

   // R7: medium blocks wait for a quarter of the buffer
   p_hold_qtr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !imm_mode && words >= WORDS_W'(HALF) && words < WORDS_W'(Q3) && !active
      && level < LVL_W'(QTR) |=> !start_stb);

   // R8: small blocks wait for the whole block
   p_hold_full_blk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !imm_mode && words < WORDS_W'(HALF) && !active
      && {{(WORDS_W-LVL_W){1'b0}}, level} < words |=> !start_stb);

   // R10: strobe lasts one cycle and coincides with an active transfer
   p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_stb |=> !start_stb);
   p_pulse_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_stb |-> active && !$past(active));

   // R11: popping the final word ends the transfer
   p_block_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      active && pop_en && last |=> !active);

endmodule

// File: rtl/ctf_flow_err.sv
module ctf_flow_err (
   input  logic clk,
   input  logic rst_n,
   input  logic push_valid,
   input  logic full,
   input  logic pop_req,
   input  logic active,
   input  logic empty,
   input  logic rdclr_mode,
   input  logic cmd_new,
   input  logic stat_rd,
   output logic ovf_flag,
   output logic udf_flag
);

   localparam int unsigned N_FLAG = 2;

   logic [N_FLAG-1:0] ev;
   logic [N_FLAG-1:0] flag;
   logic              clr;

   assign ev[0] = push_valid && full;
   assign ev[1] = pop_req && active && empty;
   assign clr   = rdclr_mode ? stat_rd : cmd_new;

   generate
      for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)     flag[i] <= 1'b0;
            else if (ev[i]) flag[i] <= 1'b1;
            else if (clr)   flag[i] <= 1'b0;
         end
      end
   endgenerate

   assign ovf_flag = flag[0];
   assign udf_flag = flag[1];

   // R12: push into a full buffer raises overflow
   p_ovf_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && full |=> ovf_flag);

   // R13: request on an empty active transfer raises underflow
   p_udf_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req && active && empty |=> udf_flag);

   // R14: in command-clear mode a status read alone keeps the flag
   p_stat_keeps_r14: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !rdclr_mode && !cmd_new |=> ovf_flag);

   // R14: in read-clear mode a command alone keeps the flag
   p_cmd_keeps_r14: assert property (@(posedge clk) disable iff (!rst_n)
      udf_flag && rdclr_mode && !stat_rd |=> udf_flag);

endmodule

// File: rtl/card_tx_fifo_start.sv
module card_tx_fifo_start
   import ctf_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned BLEN_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_wr,
   input  logic [31:0]                cfg_wdata,
   input  logic                       wp_en,
   output logic [31:0]                cfg_rdata,
   output logic                       hs_mode,
   output logic                       last_sync,
   input  logic [BLEN_W-1:0]          blk_bytes,
   input  logic                       cmd_new,
   input  logic                       stat_rd,
   input  logic                       push_valid,
   input  logic [DATA_W-1:0]          push_data,
   output logic                       push_ready,
   input  logic                       pop_req,
   output logic                       pop_valid,
   output logic [DATA_W-1:0]          pop_data,
   output logic                       start_stb,
   output logic                       xfer_active,
   output logic [$clog2(DEPTH+1)-1:0] fill_level,
   output logic                       ovf_flag,
   output logic                       udf_flag
);

   localparam int unsigned BPW     = DATA_W / 8;
   localparam int unsigned BPW_LOG = (BPW > 1) ? $clog2(BPW) : 0;

   initial begin
      assert (DATA_W % 8 == 0) else $error("DATA_W must be whole bytes");
      assert ((1 << BPW_LOG) == BPW) else $error("bytes per word must be a power of two");
      assert (CTF_REG_W == 32) else $error("register width mismatch");
   end

   ctf_cfg_t cfg;
   logic     full, empty;
   logic     push_en, pop_en;

   ctf_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr),
      .wp_en (wp_en),
      .wdata (cfg_wdata),
      .cfg   (cfg),
      .rdata (cfg_rdata)
   );

   assign hs_mode   = cfg.hs;
   assign last_sync = cfg.lsync;

   assign push_ready = !full;
   assign push_en    = push_valid && !full;
   assign pop_valid  = xfer_active && !empty;
   assign pop_en     = pop_req && pop_valid;

   ctf_fifo_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (push_en),
      .push_data (push_data),
      .pop_en    (pop_en),
      .pop_data  (pop_data),
      .level     (fill_level),
      .full      (full),
      .empty     (empty)
   );

   ctf_start_ctrl #(
      .DEPTH   (DEPTH),
      .BLEN_W  (BLEN_W),
      .BPW_LOG (BPW_LOG)
   ) u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_bytes (blk_bytes),
      .imm_mode  (cfg.imm),
      .level     (fill_level),
      .pop_en    (pop_en),
      .start_stb (start_stb),
      .active    (xfer_active)
   );

   ctf_flow_err u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (push_valid),
      .full       (full),
      .pop_req    (pop_req),
      .active     (xfer_active),
      .empty      (empty),
      .rdclr_mode (cfg.rdclr),
      .cmd_new    (cmd_new),
      .stat_rd    (stat_rd),
      .ovf_flag   (ovf_flag),
      .udf_flag   (udf_flag)
   );

   // R4: offered data only while a transfer runs
   p_offer_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> xfer_active && fill_level != '0);

endmodule

// File: tb/tb_card_tx_fifo_start.sv
`timescale 1ns/1ps
module tb_card_tx_fifo_start;

   localparam int DW    = 32;
   localparam int DEPTH = 32;
   localparam int BLW   = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_wr, wp_en, cmd_new, stat_rd, push_valid, pop_req;
   logic [31:0]   cfg_wdata, cfg_rdata;
   logic          hs_mode, last_sync, push_ready, pop_valid, start_stb, xfer_active;
   logic          ovf_flag, udf_flag;
   logic [BLW-1:0] blk_bytes;
   logic [DW-1:0] push_data, pop_data;
   logic [5:0]    fill_level;

   always #2.5 clk = ~clk;

   card_tx_fifo_start #(.DATA_W(DW), .DEPTH(DEPTH), .BLEN_W(BLW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .wp_en(wp_en),
      .cfg_rdata(cfg_rdata), .hs_mode(hs_mode), .last_sync(last_sync),
      .blk_bytes(blk_bytes), .cmd_new(cmd_new), .stat_rd(stat_rd),
      .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
      .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
      .start_stb(start_stb), .xfer_active(xfer_active), .fill_level(fill_level),
      .ovf_flag(ovf_flag), .udf_flag(udf_flag));

   int checks = 0, errors = 0;
   bit finished = 0;
   string cfg_tag = "R2", start_tag = "R10";

   // reference model state
   int          m_fill, m_head, m_tail, m_popped;
   bit          m_active, m_start, m_ovf, m_udf;
   logic [31:0] m_cfg;
   logic [DW-1:0] m_q [DEPTH];
   logic [DW-1:0] wseq = 32'h1000_0000;

   function automatic int words_of(int bytes);
      return (bytes == 0) ? 1 : (bytes + 3) / 4;
   endfunction

   function automatic int thr_of(bit imm, int w);
      if (imm) return 1;
      if (w >= 24) return 16;
      if (w >= 16) return 8;
      return w;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      int w, thr;
      bit push_acc, pop_acc, ovf_ev, udf_ev, clr, go;
      if (!rst_n) begin
         m_fill = 0; m_head = 0; m_tail = 0; m_popped = 0;
         m_active = 0; m_start = 0; m_ovf = 0; m_udf = 0; m_cfg = '0;
         return;
      end
      w        = words_of(int'(blk_bytes));
      thr      = thr_of(m_cfg[0], w);
      push_acc = push_valid && (m_fill < DEPTH);
      ovf_ev   = push_valid && (m_fill == DEPTH);
      pop_acc  = pop_req && m_active && (m_fill > 0);
      udf_ev   = pop_req && m_active && (m_fill == 0);
      clr      = m_cfg[4] ? stat_rd : cmd_new;
      go       = !m_active && (m_fill >= thr);
      if (push_acc) begin m_q[m_tail] = push_data; m_tail = (m_tail + 1) % DEPTH; end
      if (pop_acc)  m_head = (m_head + 1) % DEPTH;
      m_fill = m_fill + int'(push_acc) - int'(pop_acc);
      m_ovf  = ovf_ev ? 1'b1 : (clr ? 1'b0 : m_ovf);
      m_udf  = udf_ev ? 1'b1 : (clr ? 1'b0 : m_udf);
      if (cfg_wr && !wp_en) m_cfg = cfg_wdata & 32'h0000_1111;
      m_start = go;
      if (go) begin m_active = 1; m_popped = 0; end
      else if (pop_acc) begin
         if (m_popped == w - 1) begin m_active = 0; m_popped = 0; end
         else m_popped++;
      end
   endtask

   task automatic compare_all();
      bit pv;
      pv = m_active && (m_fill > 0);
      chk(cfg_tag, "cfg_rdata", cfg_rdata, m_cfg);
      chk("R2", "hs_mode", {31'b0, hs_mode}, {31'b0, m_cfg[8]});
      chk("R2", "last_sync", {31'b0, last_sync}, {31'b0, m_cfg[12]});
      chk("R4", "fill_level", {26'b0, fill_level}, m_fill);
      chk("R4", "pop_valid", {31'b0, pop_valid}, {31'b0, pv});
      if (pv) chk("R4", "pop_data", pop_data, m_q[m_head]);
      chk("R12", "push_ready", {31'b0, push_ready}, {31'b0, m_fill < DEPTH});
      chk(start_tag, "start_stb", {31'b0, start_stb}, {31'b0, m_start});
      chk("R11", "xfer_active", {31'b0, xfer_active}, {31'b0, m_active});
      chk("R12", "ovf_flag", {31'b0, ovf_flag}, {31'b0, m_ovf});
      chk("R13", "udf_flag", {31'b0, udf_flag}, {31'b0, m_udf});
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      cfg_wr = 0; wp_en = 0; cmd_new = 0; stat_rd = 0;
      push_valid = 0; pop_req = 0; cfg_wdata = '0;
   endtask

   task automatic do_reset();
      idle();
      rst_n = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      chk("R1", "fill after reset", {26'b0, fill_level}, 0);
      chk("R1", "push_ready after reset", {31'b0, push_ready}, 1);
      chk("R1", "ovf after reset", {31'b0, ovf_flag}, 0);
      chk("R1", "udf after reset", {31'b0, udf_flag}, 0);
      chk("R1", "cfg after reset", cfg_rdata, 0);
      chk("R1", "active after reset", {30'b0, start_stb, xfer_active}, 0);
   endtask

   task automatic write_cfg(logic [31:0] v, bit prot);
      cfg_wr = 1; cfg_wdata = v; wp_en = prot;
      tick();
      cfg_wr = 0; wp_en = 0;
   endtask

   task automatic push1();
      push_valid = 1; push_data = wseq; wseq++;
      tick();
      push_valid = 0;
   endtask

   task automatic drain(string tag, int exp_pops);
      int pops = 0;
      push_valid = 0;
      while (m_active) begin
         pop_req = 1;
         if (m_fill > 0) pops++;
         tick();
      end
      pop_req = 0;
      chk(tag, "words popped in block", pops, exp_pops);
      tick();
   endtask

   task automatic thr_test(string tag, bit imm, int bytes, int exp_thr);
      int n = 0;
      bit seen = 0;
      int w;
      w = words_of(bytes);
      blk_bytes = BLW'(bytes);
      write_cfg({31'b0, imm}, 0);
      start_tag = tag;
      while (!seen && n < DEPTH) begin
         push1();
         n++;
         tick();
         if (start_stb) seen = 1;
      end
      start_tag = "R10";
      chk(tag, "fill at start", n, exp_thr);
      while (n < w) begin push1(); n++; end
      drain("R11", w);
   endtask

   initial begin
      rst_n = 0; blk_bytes = '0; push_data = '0;
      idle();
      void'($urandom(32'd1234));
      do_reset();

      // configuration layout and protection
      write_cfg(32'hFFFF_FFFF, 0);
      tick();
      chk("R2", "all-ones readback", cfg_rdata, 32'h0000_1111);
      cfg_tag = "R3";
      write_cfg(32'h0000_0000, 1);
      tick();
      chk("R3", "protected write ignored", cfg_rdata, 32'h0000_1111);
      cfg_tag = "R2";
      write_cfg(32'h0000_0000, 0);

      // start thresholds and band edges
      thr_test("R6", 0, 100, 16);
      thr_test("R6", 0, 96, 16);
      thr_test("R7", 0, 92, 8);
      thr_test("R7", 0, 64, 8);
      thr_test("R8", 0, 60, 15);
      thr_test("R9", 0, 26, 7);
      thr_test("R9", 0, 0, 1);
      thr_test("R5", 1, 100, 1);

      // overflow and flag clearing, command-clear mode
      blk_bytes = 16'd4000;
      write_cfg(32'h0, 0);
      for (int i = 0; i < DEPTH + 1; i++) push1();
      tick();
      chk("R12", "overflow set", {31'b0, ovf_flag}, 1);
      chk("R12", "full not ready", {31'b0, push_ready}, 0);
      stat_rd = 1; tick(); stat_rd = 0; tick();
      chk("R14", "stat_rd ignored in mode 0", {31'b0, ovf_flag}, 1);
      cmd_new = 1; tick(); cmd_new = 0; tick();
      chk("R14", "cmd_new clears in mode 0", {31'b0, ovf_flag}, 0);
      // read-clear mode
      write_cfg(32'h10, 0);
      push1(); tick();
      chk("R12", "overflow set again", {31'b0, ovf_flag}, 1);
      cmd_new = 1; tick(); cmd_new = 0; tick();
      chk("R14", "cmd_new ignored in mode 1", {31'b0, ovf_flag}, 1);
      stat_rd = 1; push_valid = 1; push_data = wseq; tick(); stat_rd = 0; push_valid = 0; tick();
      chk("R14", "event beats clear", {31'b0, ovf_flag}, 1);
      stat_rd = 1; tick(); stat_rd = 0; tick();
      chk("R14", "stat_rd clears in mode 1", {31'b0, ovf_flag}, 0);
      do_reset();

      // underflow
      blk_bytes = 16'd8;
      write_cfg(32'h1, 0);
      push1(); tick();
      pop_req = 1; tick(); tick(); pop_req = 0; tick();
      chk("R13", "underflow set", {31'b0, udf_flag}, 1);
      chk("R11", "still active mid-block", {31'b0, xfer_active}, 1);
      push1();
      drain("R11", 1);
      cmd_new = 1; tick(); cmd_new = 0; tick();
      chk("R14", "underflow cleared", {31'b0, udf_flag}, 0);

      // random traffic against the model
      for (int c = 0; c < 4000; c++) begin
         push_valid = ($urandom % 3) != 0;
         push_data  = $urandom;
         pop_req    = ($urandom % 2) == 0;
         stat_rd    = ($urandom % 8) == 0;
         cmd_new    = ($urandom % 8) == 0;
         cfg_wr     = ($urandom % 64) == 0;
         wp_en      = ($urandom % 2) == 0;
         cfg_wdata  = $urandom;
         if (!m_active && ($urandom % 16) == 0) blk_bytes = BLW'($urandom % 200);
         tick();
      end
      idle();
      tick();

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(150000 * 5);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule